// File: doc/BRIEF.md
# FP16 Pooling and Activation Post-Processor

This block handles the non-convolution layer work that follows a filter stage. Each valid beat carries up to eight half-precision values together with a lane-count select, an operation select and two flags. In pooling mode it reduces the selected lanes to their largest value. Through a feedback multiplexer it can also fold in a maximum kept from earlier beats, so one pooling window may be spread over several beats. In activation mode it applies ReLU or a coarse hardware sigmoid or tanh to every selected lane.

A typical pooling window starts with a beat that has both the clear and the accumulate flags set. Later beats of the same window set only the accumulate flag, and the output of the last beat is the window maximum. Activation beats leave the pooling state untouched, so they can be interleaved with a window that is still open. Every result is registered and appears one cycle after its beat.

Top module: `pool_act_unit`

## Requirements
- R1: While `rstN` is low, and immediately after it is released, `outValid` is 0, `outMax` is 16'h0000 and `outAct` is all zeros. The held running maximum resets to negative infinity (16'hFC00).
- R2: A beat with `inValid` high gives `outValid` high on the next cycle. A cycle without a beat gives `outValid` low on the next cycle, and `outMax` and `outAct` keep their values.
- R3: The count select `countSel` picks how many lanes a beat uses, counted from lane 0 (lane i is `inData[16*i+15:16*i]`): 0 selects 4 lanes, 1 selects 6, and 2 or 3 select 8. Lanes beyond the count have no effect on any output.
- R4: Pooling mode (`opMode` 0) sets `outMax` to the bit pattern of the largest selected lane, compared by numeric value. NaN lanes are skipped, and -0 equals +0. When values tie, the lowest lane wins. When every selected lane is NaN, the beat maximum is 16'hFC00. A pooling beat sets `outAct` to zero.
- R5: With `accEn` high on a pooling beat, the result is the held maximum if that value is strictly greater than the beat maximum, and the beat maximum otherwise. The result is also written back as the new held maximum.
- R6: With `clrEn` high on a pooling beat, negative infinity takes the place of the held maximum for that beat. If `accEn` is low on that beat, the held maximum becomes 16'hFC00.
- R7: ReLU (`opMode` 1) outputs 16'h0000 for every selected lane whose sign bit is set, and passes every other selected lane through unchanged.
- R8: Sigmoid (`opMode` 2) outputs k/1024 for each selected lane x, where k = floor(256x + 512). When |x| is 2 or more, including infinities, the output is 0 for negative x and 1.0 (16'h3C00) for positive x. NaN lanes pass through unchanged.
- R9: Tanh (`opMode` 3) clamps each selected lane to [-1, 1]. A magnitude of 1 or more gives 16'h3C00 or 16'hBC00, taking the sign of the input. Any other value, and any NaN, passes through unchanged.
- R10: In the activation modes, lanes beyond the count output 16'h0000. An activation beat leaves both `outMax` and the held maximum unchanged, and ignores `accEn` and `clrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat present this cycle |
| opMode | input | 2 | 0 pool, 1 ReLU, 2 sigmoid, 3 tanh |
| countSel | input | 2 | Lane count: 0 four, 1 six, 2/3 eight |
| accEn | input | 1 | Fold in the held maximum and store the result |
| clrEn | input | 1 | Use negative infinity as the held maximum |
| inData | input | 128 | Eight FP16 lanes, lane 0 in the low bits |
| outValid | output | 1 | Result registered from the previous cycle's beat |
| outMax | output | 16 | Pooling result |
| outAct | output | 128 | Activated lanes |

## Verification
Every result of this block, whether the pooled maximum, the activated lanes or the valid flag, is due exactly one clock after its beat. The bench drives each beat on a falling edge and drops `inValid` on the next falling edge, after the capturing rising edge has passed. It compares all outputs at that point, then checks once more a cycle later that `outValid` has fallen and the outputs have held. The held maximum is never read directly. Its effect shows up in `outMax` on the next accumulating beat, which the bench predicts from its own model of the stored value.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int HALF_W = 16;
  localparam logic [15:0] NEG_INF = 16'hFC00;
  localparam logic [15:0] ONE_P = 16'h3C00;

  typedef enum logic [1:0] {
    MODE_POOL    = 2'd0,
    MODE_RELU    = 2'd1,
    MODE_SIGMOID = 2'd2,
    MODE_TANH    = 2'd3
  } opMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    poolBeat;
    logic    actBeat;
    logic    accumulate;
    logic    clearStore;
    opMode_t actKind;
  } ctrlStrobes_t;

  function automatic logic isNan(input logic [15:0] h);
    return (h[14:10] == 5'h1F) && (h[9:0] != 10'd0);
  endfunction

  // monotonic unsigned key; both zeros share one key
  function automatic logic [15:0] orderKey(input logic [15:0] h);
    if (h[14:0] == 15'd0) return 16'h8000;
    else if (h[15]) return ~h;
    else return h | 16'h8000;
  endfunction

  function automatic logic [15:0] reluFn(input logic [15:0] h);
    return h[15] ? 16'h0000 : h;
  endfunction

  function automatic logic [15:0] tanhFn(input logic [15:0] h);
    if (isNan(h)) return h;
    else if (h[14:10] >= 5'd15) return {h[15], ONE_P[14:0]};
    else return h;
  endfunction

  function automatic logic [15:0] sigmoidFn(input logic [15:0] h);
    logic [10:0] mant;
    logic [24:0] mag;
    logic [31:0] acc;
    logic [10:0] k;
    logic [3:0]  lead;
    logic [20:0] norm;
    int          sh;
    if (isNan(h)) return h;
    if (h[14:10] >= 5'd16) return h[15] ? 16'h0000 : ONE_P;
    mant = {h[14:10] != 5'd0, h[9:0]};
    sh   = (h[14:10] == 5'd0) ? 0 : int'(h[14:10]) - 1;
    mag  = 25'(mant) << sh;
    acc  = h[15] ? (32'd512 << 16) - 32'(mag) : (32'd512 << 16) + 32'(mag);
    k    = acc[26:16];
    if (k == 11'd0) return 16'h0000;
    lead = 4'd0;
    for (int i = 0; i < 11; i++) if (k[i]) lead = 4'(i);
    norm = 21'(k) << (4'd10 - lead);
    return {1'b0, 5'(lead) + 5'd5, norm[9:0]};
  endfunction
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               inValid,
  input  logic [1:0]         opMode,
  input  logic [1:0]         countSel,
  input  logic               accEn,
  input  logic               clrEn,
  output ctrlStrobes_t       strobes,
  output logic [LANES-1:0]   laneMask
);
  localparam int CNT_SMALL = LANES / 2;
  localparam int CNT_MID   = (3 * LANES) / 4;
  localparam int CNT_FULL  = LANES;

  opMode_t mode;
  int      laneCount;

  assign mode = opMode_t'(opMode);

  always_comb begin
    case (countSel)
      2'd0:    laneCount = CNT_SMALL;
      2'd1:    laneCount = CNT_MID;
      default: laneCount = CNT_FULL;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : gMask
    assign laneMask[g] = (g < laneCount);
  end

  always_comb begin
    strobes.poolBeat   = inValid && (mode == MODE_POOL);
    strobes.actBeat    = inValid && (mode != MODE_POOL);
    strobes.accumulate = strobes.poolBeat && accEn;
    strobes.clearStore = strobes.poolBeat && clrEn;
    strobes.actKind    = mode;
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [LANES-1:0]          laneMask,
  input  logic [LANES*HALF_W-1:0]   inData,
  output logic                      outValid,
  output logic [HALF_W-1:0]         outMax,
  output logic [LANES*HALF_W-1:0]   outAct
);
  logic [HALF_W-1:0]       storedMax;
  logic [HALF_W-1:0]       beatBest;
  logic [HALF_W-1:0]       effStored;
  logic [HALF_W-1:0]       poolResult;
  logic [LANES*HALF_W-1:0] actVec;

  always_comb begin
    beatBest = NEG_INF;
    for (int i = 0; i < LANES; i++) begin
      if (laneMask[i] && !isNan(inData[i*HALF_W +: HALF_W]) &&
          orderKey(inData[i*HALF_W +: HALF_W]) > orderKey(beatBest))
        beatBest = inData[i*HALF_W +: HALF_W];
    end
  end

  // feedback mux: held maximum or a fresh window start
  assign effStored  = strobes.clearStore ? NEG_INF : storedMax;
  assign poolResult = (strobes.accumulate && orderKey(effStored) > orderKey(beatBest))
                      ? effStored : beatBest;

  for (genvar g = 0; g < LANES; g++) begin : gAct
    logic [HALF_W-1:0] laneIn;
    assign laneIn = inData[g*HALF_W +: HALF_W];
    always_comb begin
      if (!laneMask[g]) actVec[g*HALF_W +: HALF_W] = '0;
      else begin
        case (strobes.actKind)
          MODE_RELU:    actVec[g*HALF_W +: HALF_W] = reluFn(laneIn);
          MODE_SIGMOID: actVec[g*HALF_W +: HALF_W] = sigmoidFn(laneIn);
          MODE_TANH:    actVec[g*HALF_W +: HALF_W] = tanhFn(laneIn);
          default:      actVec[g*HALF_W +: HALF_W] = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outMax    <= '0;
      outAct    <= '0;
      storedMax <= NEG_INF;
    end else begin
      outValid <= strobes.poolBeat || strobes.actBeat;
      if (strobes.poolBeat) begin
        outMax <= poolResult;
        outAct <= '0;
        if (strobes.accumulate) storedMax <= poolResult;
        else if (strobes.clearStore) storedMax <= NEG_INF;
      end
      if (strobes.actBeat) outAct <= actVec;
    end
  end
endmodule

// File: rtl/pool_act_unit.sv
module pool_act_unit
  import pa_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [1:0]              opMode,
  input  logic [1:0]              countSel,
  input  logic                    accEn,
  input  logic                    clrEn,
  input  logic [LANES*16-1:0]     inData,
  output logic                    outValid,
  output logic [15:0]             outMax,
  output logic [LANES*16-1:0]     outAct
);
  ctrlStrobes_t     strobes;
  logic [LANES-1:0] laneMask;

  pa_ctrl #(.LANES(LANES)) uCtrl (
    .inValid  (inValid),
    .opMode   (opMode),
    .countSel (countSel),
    .accEn    (accEn),
    .clrEn    (clrEn),
    .strobes  (strobes),
    .laneMask (laneMask)
  );

  pa_datapath #(.LANES(LANES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .laneMask (laneMask),
    .inData   (inData),
    .outValid (outValid),
    .outMax   (outMax),
    .outAct   (outAct)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int LANES = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [1:0]          opMode,
  input logic [LANES*16-1:0] inData,
  input logic                outValid,
  input logic [15:0]         outMax,
  input logic [LANES*16-1:0] outAct
);
  logic [LANES-1:0] actSigns;
  logic             lane0Nan;

  for (genvar g = 0; g < LANES; g++) begin : gSign
    assign actSigns[g] = outAct[g*16 + 15];
  end
  assign lane0Nan = (inData[14:10] == 5'h1F) && (inData[9:0] != 10'd0);

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_next: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outMax) && $stable(outAct)));
  a_r4_no_nan_max: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opMode == 2'd0) |=> !((outMax[14:10] == 5'h1F) && (outMax[9:0] != 10'd0)));
  a_r4_pool_act_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opMode == 2'd0) |=> (outAct == '0));
  a_r7_relu_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opMode == 2'd1) |=> (actSigns == '0));
  a_r9_tanh_bound: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opMode == 2'd3 && !lane0Nan) |=> (outAct[14:0] <= 15'h3C00));
  a_r10_max_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opMode != 2'd0) |=> $stable(outMax));
endmodule

bind pool_act_unit pa_checker #(.LANES(LANES)) uChk (.*);

// File: tb/sim_pool_act_unit.sv
module sim_pool_act_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [1:0]        opMode;
  logic [1:0]        countSel;
  logic              accEn;
  logic              clrEn;
  logic [LANES*16-1:0] inData;
  logic              outValid;
  logic [15:0]       outMax;
  logic [LANES*16-1:0] outAct;

  int checks = 0;
  int errors = 0;
  logic [15:0] modelStored;

  always #(CLK_PERIOD/2) clk = ~clk;

  pool_act_unit #(.LANES(LANES)) u0 (.*);

  function automatic bit nanOf(logic [15:0] h);
    return (h[14:10] == 5'h1F) && (h[9:0] != 0);
  endfunction

  // numeric value; infinities become +/-65536, which still orders correctly
  function automatic real valOf(logic [15:0] h);
    int  e = int'(h[14:10]);
    real r = (e == 0) ? real'(h[9:0]) : real'(1024 + int'(h[9:0]));
    int  s = ((e == 0) ? 1 : e) - 25;
    for (int i = 0; i < s; i++) r = r * 2.0;
    for (int i = 0; i < -s; i++) r = r / 2.0;
    return h[15] ? -r : r;
  endfunction

  function automatic int cntOf(logic [1:0] c);
    return (c == 0) ? 4 : (c == 1) ? 6 : 8;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic checkReal(string req, real got, real exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %f expected %f", req, got, exp);
    end
  endtask

  // one beat, result compared after the capturing edge, hold checked a cycle later
  task automatic beat(logic [1:0] mode, logic [1:0] cs, logic acc, logic clr,
                      logic [127:0] data);
    logic [15:0] best, eff, res, lane, got;
    logic [15:0] prevMax;
    logic [127:0] prevAct;
    int n = cntOf(cs);
    @(negedge clk);
    prevMax = outMax;
    inValid = 1; opMode = mode; countSel = cs; accEn = acc; clrEn = clr; inData = data;
    @(negedge clk);
    inValid = 0;
    check("R2 valid", 128'(outValid), 128'(1));
    if (mode == 0) begin
      best = 16'hFC00;
      for (int i = 0; i < n; i++) begin
        lane = data[i*16 +: 16];
        if (!nanOf(lane) && valOf(lane) > valOf(best)) best = lane;
      end
      eff = clr ? 16'hFC00 : modelStored;
      res = (acc && valOf(eff) > valOf(best)) ? eff : best;
      check("R3 R4 R5 R6 pool max", 128'(outMax), 128'(res));
      check("R4 pool act zero", outAct, 128'(0));
      if (acc) modelStored = res;
      else if (clr) modelStored = 16'hFC00;
    end else begin
      check("R10 max held", 128'(outMax), 128'(prevMax));
      for (int i = 0; i < LANES; i++) begin
        lane = data[i*16 +: 16];
        got  = outAct[i*16 +: 16];
        if (i >= n) check("R10 lane zero", 128'(got), 128'(0));
        else if (mode == 1) check("R7 relu", 128'(got), 128'(lane[15] ? 16'h0 : lane));
        else if (mode == 3) begin
          if (!nanOf(lane) && valOf(lane) >= 1.0) check("R9 tanh hi", 128'(got), 128'(16'h3C00));
          else if (!nanOf(lane) && valOf(lane) <= -1.0) check("R9 tanh lo", 128'(got), 128'(16'hBC00));
          else check("R9 tanh pass", 128'(got), 128'(lane));
        end else begin
          if (nanOf(lane)) check("R8 sigmoid nan", 128'(got), 128'(lane));
          else if (valOf(lane) >= 2.0) checkReal("R8 sigmoid hi", valOf(got), 1.0);
          else if (valOf(lane) <= -2.0) checkReal("R8 sigmoid lo", valOf(got), 0.0);
          else checkReal("R8 sigmoid", valOf(got), $floor(valOf(lane) * 256.0 + 512.0) / 1024.0);
        end
      end
    end
    prevMax = outMax; prevAct = outAct;
    @(negedge clk);
    check("R2 idle valid", 128'(outValid), 128'(0));
    check("R2 hold", {outMax, outAct[111:0]}, {prevMax, prevAct[111:0]});
  endtask

  function automatic logic [127:0] pack8(logic [15:0] a, b, c, d, e, f, g, h);
    return {h, g, f, e, d, c, b, a};
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; inValid = 0; opMode = 0; countSel = 0; accEn = 0; clrEn = 0; inData = '0;
    modelStored = 16'hFC00;
    repeat (4) @(negedge clk);
    check("R1 reset valid", 128'(outValid), 128'(0));
    check("R1 reset max", 128'(outMax), 128'(0));
    check("R1 reset act", outAct, 128'(0));
    rstN = 1;
    @(negedge clk);
    check("R1 after release", {127'(outMax), outValid}, 128'(0));
    // R1: held maximum starts at -inf, seen through accumulate on all-negative data
    beat(0, 2, 1, 0, pack8(16'hC800, 16'hC400, 16'hCC00, 16'hC000, 16'hD000, 16'hC200, 16'hC600, 16'hCA00));
    // R3: big values outside the selected count
    beat(0, 0, 0, 0, pack8(16'h3C00, 16'h4000, 16'h3800, 16'h3400, 16'h7800, 16'h7800, 16'h7800, 16'h7800));
    beat(0, 1, 0, 0, pack8(16'h3C00, 16'h4000, 16'h3800, 16'h3400, 16'h4400, 16'h4200, 16'h7800, 16'h7800));
    beat(0, 3, 0, 0, pack8(16'h3C00, 16'h4000, 16'h3800, 16'h3400, 16'h4400, 16'h4200, 16'h4500, 16'h4600));
    // R4: -0 ties +0, lowest lane kept
    beat(0, 0, 0, 0, pack8(16'h8000, 16'h0000, 16'hBC00, 16'hC000, 0, 0, 0, 0));
    check("R4 minus zero kept", 128'(outMax), 128'(16'h8000));
    // R4: NaN skipped, all-NaN gives -inf
    beat(0, 0, 0, 0, pack8(16'h7E00, 16'hBC00, 16'hFE01, 16'hC000, 0, 0, 0, 0));
    beat(0, 0, 0, 0, pack8(16'h7E00, 16'hFC01, 16'h7C01, 16'hFFFF, 16'h3C00, 0, 0, 0));
    check("R4 all nan", 128'(outMax), 128'(16'hFC00));
    // R5 R6: window over three beats
    beat(0, 0, 1, 1, pack8(16'h3C00, 16'h3800, 16'h3400, 16'h3000, 0, 0, 0, 0));
    beat(0, 0, 1, 0, pack8(16'hBC00, 16'h3000, 16'h2C00, 16'h2800, 0, 0, 0, 0));
    check("R5 stored wins", 128'(outMax), 128'(16'h3C00));
    beat(0, 0, 1, 0, pack8(16'h4800, 16'h3000, 16'h2C00, 16'h2800, 0, 0, 0, 0));
    // R6: clear without accumulate, then accumulate negatives
    beat(0, 0, 0, 1, pack8(16'h3000, 0, 0, 0, 0, 0, 0, 0));
    beat(0, 0, 1, 0, pack8(16'hC000, 16'hC400, 16'hC800, 16'hCC00, 0, 0, 0, 0));
    check("R6 cleared store", 128'(outMax), 128'(16'hC000));
    // R10: activation beat with flags set leaves store untouched
    beat(1, 2, 1, 1, pack8(16'h3C00, 16'hBC00, 16'h7E00, 16'hFE00, 16'h8000, 16'h0001, 16'hFC00, 16'h7C00));
    beat(0, 0, 1, 0, pack8(16'hD000, 16'hD000, 16'hD000, 16'hD000, 0, 0, 0, 0));
    check("R10 store untouched", 128'(outMax), 128'(16'hC000));
    // R8 R9 directed points
    beat(2, 2, 0, 0, pack8(16'h0000, 16'h3C00, 16'hBC00, 16'h4200, 16'hC200, 16'hC000, 16'h4000, 16'h0001));
    check("R8 sigmoid zero", 128'(outAct[15:0]), 128'(16'h3800));
    beat(3, 1, 0, 0, pack8(16'h3C00, 16'hBC00, 16'h3BFF, 16'hC800, 16'h7C00, 16'h8001, 16'h4000, 16'h4000));
    beat(2, 0, 0, 0, pack8(16'hBFFF, 16'h3FFF, 16'h7E00, 16'h03FF, 16'h4000, 0, 0, 0));
    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [127:0] d;
      for (int i = 0; i < 4; i++) d[i*32 +: 32] = $urandom;
      if (t % 3 == 0)
        for (int i = 0; i < LANES; i++) d[i*16 + 14] = 1'b0;
      beat(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 4 == 0), d);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule